// File: doc/BRIEF.md
# Windowed Integer Register File

This block is the integer register file of a processor core that uses overlapping register windows. Software always sees 32 registers: 8 globals that every window shares, and a 24-register window made of an out group, a local group and an in group. A window's in group is the same physical storage as the out group of the next-higher window. Because of this, a procedure call that moves to a lower window finds the caller's outgoing arguments already in place as its incoming ones. The window count `NWIN` is a parameter. The array holds 8 + 16 x NWIN physical words.

The core reads two operands per cycle and writes one result. It can also ask the block to step the current window pointer. A save step moves down one window and a restore step moves up one window. Both steps read their sources in the old window and write a supplied sum into the new window. A window invalid mask is checked before each step, and a step that would land on a marked window raises an overflow or underflow trap instead of moving. A trap-entry input moves the window down without that check and records two program-counter values in the new window. The mask can be loaded or rotated by one place in either direction, which is how the spill and fill handlers advance it.

Top module: `win_regfile`

## Requirements
- R1: Register addresses decode by bits [4:3]: 0 selects a global shared by all windows, 1 an out, 2 a local, 3 an in; locals of one window are not visible from any other window.
- R2: Any read port addressing register 0 returns zero, and a write to register 0 from any write source is discarded.
- R3: A completed save step (`opCmd`=2'b01) sets `cwp` to `cwp`-1 and a completed restore step (`opCmd`=2'b10) sets it to `cwp`+1, both modulo `NWIN`, so window 0 and window `NWIN`-1 are neighbours; `opCmd`=2'b00 or 2'b11 leaves `cwp` alone.
- R4: Out register k of window w is the same storage as in register k of window w-1 (mod `NWIN`), so after a save the old register 14 reads back as register 30.
- R5: During a save or restore, both read ports still decode with the old `cwp`, and `opSum` is written to register `opRd` of the new window at the clock edge that updates `cwp`.
- R6: A save whose target window has its `wim` bit set raises `ovfTrap` combinationally in that cycle, and neither `cwp` nor any register changes.
- R7: A restore whose target window has its `wim` bit set raises `unfTrap` combinationally in that cycle, and neither `cwp` nor any register changes.
- R8: `trapEnter` decrements `cwp` modulo `NWIN` regardless of `wim`, and writes `trapPc` to register 17 and `trapNpc` to register 18 of the new window.
- R9: `wimCmd` 2'b01 loads `wimWrData`, 2'b10 rotates `wim` right by one place (bit 0 moves to bit `NWIN`-1), 2'b11 rotates it left by one place (bit `NWIN`-1 moves to bit 0), and 2'b00 holds it.
- R10: A read of a register written in the same cycle returns the value held before that write.
- R11: Reset sets `cwp` to 0, `wim` to all zeros and every physical register to zero.
- R12: `trapEnter` takes priority over `opCmd`, so no window trap is raised during trap entry; the plain write port is ignored in any cycle that carries `trapEnter` or a save/restore request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rdAddrA | input | 5 | Read port A register address |
| rdDataA | output | DATA_W | Read port A data (old window during a step) |
| rdAddrB | input | 5 | Read port B register address |
| rdDataB | output | DATA_W | Read port B data |
| wrEn | input | 1 | Plain write enable, current window |
| wrAddr | input | 5 | Plain write register address |
| wrData | input | DATA_W | Plain write data |
| opCmd | input | 2 | Window step: 00 none, 01 save, 10 restore, 11 none |
| opRd | input | 5 | Destination register of the step, in the new window |
| opSum | input | DATA_W | Sum already computed outside, written to `opRd` |
| trapEnter | input | 1 | Trap entry: step down without the mask check |
| trapPc | input | DATA_W | Value recorded in register 17 of the trap window |
| trapNpc | input | DATA_W | Value recorded in register 18 of the trap window |
| wimCmd | input | 2 | Mask command: 00 hold, 01 load, 10 rotate right, 11 rotate left |
| wimWrData | input | NWIN | Mask load value |
| cwp | output | 5 | Current window pointer |
| wim | output | NWIN | Window invalid mask |
| ovfTrap | output | 1 | Save blocked by the mask (this cycle) |
| unfTrap | output | 1 | Restore blocked by the mask (this cycle) |

## Verification
The hardest case to reach is the wrap-around seam, where window 0 borders window `NWIN`-1. A fault there shows only as an in/out alias that resolves to the wrong physical word, or a blocked step that still moves the pointer. The stimulus saves out of window 0 into the top window, then restores from 0 into 1 and reads the alias in both directions. It then places mask bits exactly on the target windows of a save and a restore, so both traps fire at the seam. The trap-entry cycle also carries a conflicting restore and plain write, so the priority rules are exercised in the same step.

// File: rtl/winrf_pkg.sv
package winrf_pkg;

  localparam int REG_AW = 5;
  localparam int CWP_W  = 5;

  typedef enum logic [1:0] {
    OP_NONE    = 2'b00,
    OP_SAVE    = 2'b01,
    OP_RESTORE = 2'b10,
    OP_RSVD    = 2'b11
  } winOp_e;

  typedef enum logic [1:0] {
    WIM_HOLD = 2'b00,
    WIM_LOAD = 2'b01,
    WIM_ROR  = 2'b10,
    WIM_ROL  = 2'b11
  } wimCmd_e;

  // strobes from the window control to the register datapath
  typedef struct packed {
    logic [CWP_W-1:0] curWin;   // window used by reads and plain writes
    logic [CWP_W-1:0] nextWin;  // window used by step and trap writes
    logic             plainWr;
    logic             opWr;
    logic             trapWr;
  } rfStrobes_t;

endpackage

// File: rtl/winrf_ctrl.sv
module winrf_ctrl
  import winrf_pkg::*;
#(
  parameter int NWIN = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       opCmd,
  input  logic             trapEnter,
  input  logic             wrEn,
  input  logic [1:0]       wimCmd,
  input  logic [NWIN-1:0]  wimWrData,
  output rfStrobes_t       strobes,
  output logic [CWP_W-1:0] cwp,
  output logic [NWIN-1:0]  wim,
  output logic             ovfTrap,
  output logic             unfTrap
);

  localparam int IDX_W = (NWIN > 1) ? $clog2(NWIN) : 1;
  localparam logic [CWP_W-1:0] TOP_WIN = CWP_W'(NWIN - 1);

  logic [CWP_W-1:0] cwpQ, cwpD, decWin, incWin;
  logic [NWIN-1:0]  wimQ, wimD;
  winOp_e           opKind;
  wimCmd_e          wimKind;
  logic             isSave, isRestore, stepReq, stepOk;

  always_comb begin
    opKind  = winOp_e'(opCmd);
    wimKind = wimCmd_e'(wimCmd);
    decWin  = (cwpQ == '0) ? TOP_WIN : cwpQ - 1'b1;
    incWin  = (cwpQ == TOP_WIN) ? '0 : cwpQ + 1'b1;

    // trap entry overrides any window step in the same cycle
    isSave    = !trapEnter && (opKind == OP_SAVE);
    isRestore = !trapEnter && (opKind == OP_RESTORE);
    stepReq   = (opKind == OP_SAVE) || (opKind == OP_RESTORE);

    ovfTrap = isSave    && wimQ[decWin[IDX_W-1:0]];
    unfTrap = isRestore && wimQ[incWin[IDX_W-1:0]];
    stepOk  = (isSave && !ovfTrap) || (isRestore && !unfTrap);

    if (trapEnter)                  cwpD = decWin;
    else if (isSave && !ovfTrap)    cwpD = decWin;
    else if (isRestore && !unfTrap) cwpD = incWin;
    else                            cwpD = cwpQ;

    unique case (wimKind)
      WIM_LOAD: wimD = wimWrData;
      WIM_ROR:  wimD = {wimQ[0], wimQ[NWIN-1:1]};
      WIM_ROL:  wimD = {wimQ[NWIN-2:0], wimQ[NWIN-1]};
      default:  wimD = wimQ;
    endcase

    strobes.curWin  = cwpQ;
    strobes.nextWin = cwpD;
    strobes.opWr    = stepOk;
    strobes.trapWr  = trapEnter;
    strobes.plainWr = wrEn && !trapEnter && !stepReq;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cwpQ <= '0;
      wimQ <= '0;
    end else begin
      cwpQ <= cwpD;
      wimQ <= wimD;
    end
  end

  assign cwp = cwpQ;
  assign wim = wimQ;

endmodule

// File: rtl/winrf_dp.sv
module winrf_dp
  import winrf_pkg::*;
#(
  parameter int NWIN   = 8,
  parameter int DATA_W = 32,
  parameter int NRD    = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  rfStrobes_t              strobes,
  input  logic [NRD-1:0][REG_AW-1:0] rdAddr,
  output logic [NRD-1:0][DATA_W-1:0] rdData,
  input  logic [REG_AW-1:0]       wrAddr,
  input  logic [DATA_W-1:0]       wrData,
  input  logic [REG_AW-1:0]       opRd,
  input  logic [DATA_W-1:0]       opSum,
  input  logic [DATA_W-1:0]       trapPc,
  input  logic [DATA_W-1:0]       trapNpc
);

  localparam int NGLOB   = 8;
  localparam int WIN_REGS = 16;
  localparam int NPHYS   = NGLOB + WIN_REGS * NWIN;
  localparam int PIDX_W  = $clog2(NPHYS);
  localparam logic [REG_AW-1:0] TRAP_PC_REG  = REG_AW'(17);
  localparam logic [REG_AW-1:0] TRAP_NPC_REG = REG_AW'(18);

  logic [DATA_W-1:0] rf [NPHYS];

  // architectural address plus window -> physical slot
  function automatic logic [PIDX_W-1:0] physIdx(input logic [REG_AW-1:0] ra,
                                                 input logic [CWP_W-1:0] win);
    int w;
    int slot;
    w = int'(win);
    unique case (ra[4:3])
      2'd0: slot = int'(ra);
      2'd1: slot = NGLOB + WIN_REGS * w + int'(ra[2:0]);
      2'd2: slot = NGLOB + WIN_REGS * w + 8 + int'(ra[2:0]);
      default: begin
        w    = (w == NWIN - 1) ? 0 : w + 1;
        slot = NGLOB + WIN_REGS * w + int'(ra[2:0]);
      end
    endcase
    return PIDX_W'(slot);
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NPHYS; i++) rf[i] <= '0;
    end else begin
      if (strobes.plainWr && (wrAddr != '0))
        rf[physIdx(wrAddr, strobes.curWin)] <= wrData;
      if (strobes.opWr && (opRd != '0))
        rf[physIdx(opRd, strobes.nextWin)] <= opSum;
      if (strobes.trapWr) begin
        rf[physIdx(TRAP_PC_REG, strobes.nextWin)]  <= trapPc;
        rf[physIdx(TRAP_NPC_REG, strobes.nextWin)] <= trapNpc;
      end
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rdPort
    always_comb begin
      if (rdAddr[p] == '0) rdData[p] = '0;
      else                 rdData[p] = rf[physIdx(rdAddr[p], strobes.curWin)];
    end
  end

endmodule

// File: rtl/win_regfile.sv
module win_regfile
  import winrf_pkg::*;
#(
  parameter int NWIN   = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [4:0]        rdAddrA,
  output logic [DATA_W-1:0] rdDataA,
  input  logic [4:0]        rdAddrB,
  output logic [DATA_W-1:0] rdDataB,
  input  logic              wrEn,
  input  logic [4:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [1:0]        opCmd,
  input  logic [4:0]        opRd,
  input  logic [DATA_W-1:0] opSum,
  input  logic              trapEnter,
  input  logic [DATA_W-1:0] trapPc,
  input  logic [DATA_W-1:0] trapNpc,
  input  logic [1:0]        wimCmd,
  input  logic [NWIN-1:0]   wimWrData,
  output logic [4:0]        cwp,
  output logic [NWIN-1:0]   wim,
  output logic              ovfTrap,
  output logic              unfTrap
);

  rfStrobes_t strobes;
  logic [1:0][REG_AW-1:0] rdAddr;
  logic [1:0][DATA_W-1:0] rdData;

  assign rdAddr  = {rdAddrB, rdAddrA};
  assign rdDataA = rdData[0];
  assign rdDataB = rdData[1];

  winrf_ctrl #(.NWIN(NWIN)) u_ctrl (
    .clk(clk), .rstN(rstN), .opCmd(opCmd), .trapEnter(trapEnter), .wrEn(wrEn),
    .wimCmd(wimCmd), .wimWrData(wimWrData), .strobes(strobes), .cwp(cwp),
    .wim(wim), .ovfTrap(ovfTrap), .unfTrap(unfTrap)
  );

  winrf_dp #(.NWIN(NWIN), .DATA_W(DATA_W), .NRD(2)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .rdAddr(rdAddr), .rdData(rdData),
    .wrAddr(wrAddr), .wrData(wrData), .opRd(opRd), .opSum(opSum),
    .trapPc(trapPc), .trapNpc(trapNpc)
  );

endmodule

// File: rtl/win_regfile_chk.sv
module win_regfile_chk #(
  parameter int NWIN   = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic [4:0]        rdAddrA,
  input logic [DATA_W-1:0] rdDataA,
  input logic [4:0]        rdAddrB,
  input logic [DATA_W-1:0] rdDataB,
  input logic [1:0]        opCmd,
  input logic              trapEnter,
  input logic [1:0]        wimCmd,
  input logic [4:0]        cwp,
  input logic [NWIN-1:0]   wim,
  input logic              ovfTrap,
  input logic              unfTrap
);

  localparam logic [4:0] TOPW = 5'(NWIN - 1);

  p_cwp_in_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    cwp <= TOPW);

  p_save_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (opCmd == 2'b01 && !trapEnter && !ovfTrap) |=>
      cwp == (($past(cwp) == 5'd0) ? TOPW : $past(cwp) - 5'd1));

  p_restore_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (opCmd == 2'b10 && !trapEnter && !unfTrap) |=>
      cwp == (($past(cwp) == TOPW) ? 5'd0 : $past(cwp) + 5'd1));

  p_zero_read_a_r2: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddrA == 5'd0) |-> (rdDataA == '0));

  p_zero_read_b_r2: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddrB == 5'd0) |-> (rdDataB == '0));

  p_ovf_holds_cwp_r6: assert property (@(posedge clk) disable iff (!rstN)
    ovfTrap |=> $stable(cwp));

  p_unf_holds_cwp_r7: assert property (@(posedge clk) disable iff (!rstN)
    unfTrap |=> $stable(cwp));

  p_traps_exclusive_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ovfTrap, unfTrap}));

  p_trap_entry_dec_r8: assert property (@(posedge clk) disable iff (!rstN)
    trapEnter |=> cwp == (($past(cwp) == 5'd0) ? TOPW : $past(cwp) - 5'd1));

  p_wim_ror_r9: assert property (@(posedge clk) disable iff (!rstN)
    (wimCmd == 2'b10) |=> wim == {$past(wim[0]), $past(wim[NWIN-1:1])});

  p_wim_rol_r9: assert property (@(posedge clk) disable iff (!rstN)
    (wimCmd == 2'b11) |=> wim == {$past(wim[NWIN-2:0]), $past(wim[NWIN-1])});

  p_trap_entry_no_window_trap_r12: assert property (@(posedge clk) disable iff (!rstN)
    trapEnter |-> (!ovfTrap && !unfTrap));

endmodule

bind win_regfile win_regfile_chk #(.NWIN(NWIN), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .rdAddrA(rdAddrA), .rdDataA(rdDataA),
  .rdAddrB(rdAddrB), .rdDataB(rdDataB), .opCmd(opCmd), .trapEnter(trapEnter),
  .wimCmd(wimCmd), .cwp(cwp), .wim(wim), .ovfTrap(ovfTrap), .unfTrap(unfTrap)
);

// File: tb/win_regfile_tb.sv
`timescale 1ns/1ps
module win_regfile_tb;

  localparam int NWIN = 8;
  localparam int DW   = 32;
  localparam int K_RDA = 0, K_RDB = 1, K_CWP = 2, K_WIM = 3, K_OVF = 4, K_UNF = 5;

  logic clk = 1'b0;
  logic rstN;
  logic [4:0] rdAddrA, rdAddrB, wrAddr, opRd, cwp;
  logic [DW-1:0] rdDataA, rdDataB, wrData, opSum, trapPc, trapNpc;
  logic wrEn, trapEnter, ovfTrap, unfTrap;
  logic [1:0] opCmd, wimCmd;
  logic [NWIN-1:0] wimWrData, wim;

  int nRun = 0;
  int nFail = 0;
  bit doneFlag = 0;

  int          kindQ[$];
  logic [31:0] expQ[$];
  string       tagQ[$];
  event        monEv;

  always #4 clk = ~clk;  // 125 MHz

  win_regfile #(.NWIN(NWIN), .DATA_W(DW)) u_dut (
    .clk(clk), .rstN(rstN), .rdAddrA(rdAddrA), .rdDataA(rdDataA),
    .rdAddrB(rdAddrB), .rdDataB(rdDataB), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .opCmd(opCmd), .opRd(opRd), .opSum(opSum),
    .trapEnter(trapEnter), .trapPc(trapPc), .trapNpc(trapNpc),
    .wimCmd(wimCmd), .wimWrData(wimWrData), .cwp(cwp), .wim(wim),
    .ovfTrap(ovfTrap), .unfTrap(unfTrap)
  );

  // monitor: pops expected items and compares them with the outputs
  always begin : monitor
    int k;
    logic [31:0] e, act;
    string t;
    @(monEv);
    while (kindQ.size() > 0) begin
      k = kindQ.pop_front();
      e = expQ.pop_front();
      t = tagQ.pop_front();
      case (k)
        K_RDA:   act = rdDataA;
        K_RDB:   act = rdDataB;
        K_CWP:   act = 32'(cwp);
        K_WIM:   act = 32'(wim);
        K_OVF:   act = 32'(ovfTrap);
        default: act = 32'(unfTrap);
      endcase
      nRun++;
      if (act !== e) begin
        nFail++;
        $display("FAIL %s: actual 0x%0h expected 0x%0h", t, act, e);
      end
    end
  end

  task automatic expect_item(input int kind, input logic [31:0] v, input string tag);
    kindQ.push_back(kind);
    expQ.push_back(v);
    tagQ.push_back(tag);
  endtask

  task automatic sample();
    #2; -> monEv; #1;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic clrIn();
    rdAddrA = 0; rdAddrB = 0; wrEn = 0; wrAddr = 0; wrData = 0;
    opCmd = 2'b00; opRd = 0; opSum = 0; trapEnter = 0; trapPc = 0; trapNpc = 0;
    wimCmd = 2'b00; wimWrData = 0;
  endtask

  task automatic doWrite(input logic [4:0] a, input logic [DW-1:0] d);
    wrEn = 1; wrAddr = a; wrData = d; tick(); clrIn();
  endtask

  task automatic rdChk(input logic [4:0] a, input logic [DW-1:0] v, input string tag);
    rdAddrA = a; expect_item(K_RDA, v, tag); sample(); tick(); clrIn();
  endtask

  task automatic cwpChk(input logic [4:0] v, input string tag);
    expect_item(K_CWP, 32'(v), tag); sample(); tick();
  endtask

  task automatic step(input logic [1:0] cmd, input logic [4:0] rd, input logic [DW-1:0] s);
    opCmd = cmd; opRd = rd; opSum = s; tick(); clrIn();
  endtask

  task automatic wimOp(input logic [1:0] c, input logic [NWIN-1:0] d);
    wimCmd = c; wimWrData = d; tick(); clrIn();
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!doneFlag) begin
      nFail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin : driver
    clrIn();
    rstN = 0;
    tick(); tick();
    rstN = 1;
    tick();

    // R11: reset state
    expect_item(K_CWP, 0, "R11 cwp after reset");
    expect_item(K_WIM, 0, "R11 wim after reset");
    expect_item(K_OVF, 0, "R11 no overflow after reset");
    sample(); tick();

    // R2: register 0 stays zero
    doWrite(5'd0, 32'h5);
    rdChk(5'd0, 0, "R2 read of register 0");
    // R1: global written
    doWrite(5'd1, 32'h11);
    rdChk(5'd1, 32'h11, "R1 global readback");

    doWrite(5'd14, 32'h1000);
    doWrite(5'd16, 32'hAAAA);
    doWrite(5'd24, 32'hBB);

    // R5: save reads the old window in its own cycle, writes new window
    opCmd = 2'b01; opRd = 5'd14; opSum = 32'h0FC0; rdAddrA = 5'd14;
    expect_item(K_RDA, 32'h1000, "R5 source read in old window");
    sample(); tick(); clrIn();
    cwpChk(5'd7, "R3 save wraps 0 to NWIN-1");
    rdChk(5'd30, 32'h1000, "R4 caller r14 seen as callee r30");
    rdAddrB = 5'd14; expect_item(K_RDB, 32'h0FC0, "R5 sum written in new window");
    sample(); tick(); clrIn();
    rdChk(5'd16, 0, "R1 local of new window is private");
    rdChk(5'd1, 32'h11, "R1 global shared across windows");

    // restore back to window 0
    step(2'b10, 5'd8, 32'h77);
    cwpChk(5'd0, "R3 restore wraps NWIN-1 to 0");
    rdChk(5'd14, 32'h1000, "R4 caller stack pointer intact");
    rdChk(5'd8, 32'h77, "R5 restore sum in new window");
    rdChk(5'd16, 32'hAAAA, "R1 local of window 0 kept");
    rdChk(5'd24, 32'hBB, "R1 in of window 0 kept");

    step(2'b10, 5'd0, 32'h55);
    cwpChk(5'd1, "R3 restore increments");
    rdChk(5'd8, 32'hBB, "R4 window 0 in is window 1 out");
    step(2'b01, 5'd0, 32'h55);
    cwpChk(5'd0, "R3 save decrements");
    rdChk(5'd0, 0, "R2 step write to register 0 dropped");

    // R9 and R6
    wimOp(2'b01, 8'h80);
    expect_item(K_WIM, 32'h80, "R9 mask load"); sample(); tick();
    opCmd = 2'b01; opRd = 5'd16; opSum = 32'hDEAD;
    expect_item(K_OVF, 1, "R6 overflow raised");
    expect_item(K_UNF, 0, "R6 no underflow on save");
    sample(); tick(); clrIn();
    cwpChk(5'd0, "R6 cwp held on overflow");
    rdChk(5'd16, 32'hAAAA, "R6 destination untouched on overflow");

    wimOp(2'b10, '0);
    expect_item(K_WIM, 32'h40, "R9 rotate right"); sample(); tick();
    wimOp(2'b01, 8'h01);
    wimOp(2'b10, '0);
    expect_item(K_WIM, 32'h80, "R9 rotate right wraps bit 0"); sample(); tick();
    wimOp(2'b11, '0);
    expect_item(K_WIM, 32'h01, "R9 rotate left wraps top bit"); sample(); tick();

    // R7
    wimOp(2'b01, 8'h82);
    opCmd = 2'b10; opRd = 5'd17; opSum = 32'h9;
    expect_item(K_UNF, 1, "R7 underflow raised");
    sample(); tick(); clrIn();
    cwpChk(5'd0, "R7 cwp held on underflow");
    rdChk(5'd17, 0, "R7 destination untouched on underflow");

    // R8 and R12: trap entry with conflicting restore and plain write
    trapEnter = 1; trapPc = 32'h400; trapNpc = 32'h404;
    opCmd = 2'b10; opRd = 5'd19; opSum = 32'h1;
    wrEn = 1; wrAddr = 5'd2; wrData = 32'h99;
    expect_item(K_UNF, 0, "R12 no window trap during trap entry");
    sample(); tick(); clrIn();
    cwpChk(5'd7, "R8 trap entry ignores mask bit");
    rdChk(5'd17, 32'h400, "R8 trap pc recorded");
    rdChk(5'd18, 32'h404, "R8 trap npc recorded");
    rdChk(5'd2, 0, "R12 plain write ignored on trap entry");

    // R10: read-before-write
    wrEn = 1; wrAddr = 5'd20; wrData = 32'h5; rdAddrA = 5'd20;
    expect_item(K_RDA, 0, "R10 same-cycle read gives old value");
    sample(); tick(); clrIn();
    rdChk(5'd20, 32'h5, "R10 value after write");

    // R12: plain write ignored during a step
    opCmd = 2'b01; opRd = 5'd0; wrEn = 1; wrAddr = 5'd3; wrData = 32'h66;
    tick(); clrIn();
    cwpChk(5'd6, "R3 save from window 7");
    rdChk(5'd3, 0, "R12 plain write ignored during step");

    doneFlag = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule